// File: doc/BRIEF.md
# Serial Receive Frame Qualifier

This block sits after the bit-sampling logic of a serial receiver. It works at the moment a frame ends. On a one-cycle frame-done strobe it decides whether the frame is delivered. A delivered frame sets the receive-complete flag, loads the receive buffer and, depending on the mode, loads the ninth-bit register. A frame that is not delivered leaves all three untouched. Two rules can withhold delivery. The first is a multiprocessor address filter: in the nine-bit modes the ninth bit must mark an address, and in the eight-bit mode the stop bit must be valid. In both cases the byte must also match the station's own address or the broadcast address. The second rule is that a frame arriving while the receive flag is still set is dropped.

The block also owns the small control register that software uses for these functions. Bit 7 of this register is shared. It holds either the upper mode bit or a sticky framing-error flag, and a select input chooses which one is read and written. The framing-error flag is set whenever a UART-mode frame ends with a stop bit of 0. Only a software write clears it. All results appear one clock after the strobe or write that causes them.

Top module: `uart_rx_qualifier`

## Requirements
- R1: After reset, the mode, filter enable, ninth-bit, receive flag and framing-error registers are 0, the receive buffer is 0 and `ctl_rdata` reads 0x00.
- R2: In mode 0 (shift), a completed frame with the receive flag clear sets the flag and loads the buffer. The ninth-bit register and the framing-error flag are left unchanged, whatever the stop bit.
- R3: In modes 2 and 3 with the filter off, a completed frame with the flag clear is delivered, and the ninth-bit register takes the received ninth bit.
- R4: In mode 1 with the filter off, a completed frame is delivered even with a stop bit of 0, and the ninth-bit register takes the sampled stop bit.
- R5: In modes 2 and 3 with the filter on, a frame is delivered only if its ninth bit is 1 and its byte matches the station address (R7). A rejected frame changes neither the flag, the buffer nor the ninth-bit register.
- R6: In mode 1 with the filter on, a frame is delivered only if its stop bit is 1 and its byte matches the station address (R7). A delivered frame leaves the ninth-bit register unchanged.
- R7: A byte matches if either of two conditions holds. Own match: (byte & mask) == (addr & mask). Broadcast match: (byte & (addr | mask)) == (addr | mask).
- R8: In modes 1 to 3, a frame ending with a stop bit of 0 sets the framing-error flag, whether or not the frame is delivered. Later valid frames do not clear it.
- R9: Control bit 7 maps to the upper mode bit when `sel_fe` is 0 and to the framing-error flag when `sel_fe` is 1, for reads and for writes. A write reaches only the selected register. Other read layout: bit 6 is the lower mode bit, bit 5 is the filter enable, bit 2 is the ninth bit, bit 0 is the receive flag, and the remaining bits read 0.
- R10: A frame that completes while the receive flag is 1 is dropped: the buffer and the ninth-bit register keep their values.
- R11: `ri_clr` clears the receive flag. A delivery in the same cycle takes priority, so the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle strobe at the end of a received frame |
| rx_byte | input | DATA_W | Received data byte |
| rx_bit9 | input | 1 | Received ninth data bit |
| rx_stop | input | 1 | Sampled stop bit |
| stn_addr | input | DATA_W | Station address |
| stn_mask | input | DATA_W | Station address mask (1 = compare) |
| sel_fe | input | 1 | Selects the framing-error flag onto control bit 7 |
| ctl_wr | input | 1 | Software write strobe for the control register |
| ctl_wdata | input | 8 | Control register write data |
| ri_clr | input | 1 | Software clear strobe for the receive flag |
| ctl_rdata | output | 8 | Control register read value |
| rx_data | output | DATA_W | Receive buffer |
| ri | output | 1 | Receive-complete flag |
| fe | output | 1 | Sticky framing-error flag |
| ninth | output | 1 | Ninth-bit register |

## Verification
Some properties can be checked on every cycle. These are: a delivered frame loads the buffer and sets the flag, a busy or filter-rejected frame leaves the buffer alone, a bad stop bit sets the framing error, the framing error stays set until a clearing write, and a write with the flag selected leaves the upper mode bit alone. The bench scenarios are needed for the rest: the mode-specific choice of ninth-bit source, own versus broadcast matches, the full read layout of the shared bit 7, and the priority of delivery over a clear in the same cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'd0,
    MODE_UART8  = 2'd1,
    MODE_UART9A = 2'd2,
    MODE_UART9B = 2'd3
  } rx_mode_e;

  localparam int CTL_W    = 8;
  localparam int B_MODEHI = 7;   // shared with framing-error flag
  localparam int B_MODELO = 6;
  localparam int B_FILT   = 5;
  localparam int B_NINTH  = 2;
  localparam int B_RI     = 0;
endpackage

// File: rtl/rxq_addr_match.sv
module rxq_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_in,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] mask,
  output logic              own_hit,
  output logic              bcast_hit,
  output logic              addr_hit
);
  function automatic logic f_own(input logic [DATA_W-1:0] b,
                                 input logic [DATA_W-1:0] a,
                                 input logic [DATA_W-1:0] m);
    return ((b ^ a) & m) == '0;
  endfunction

  function automatic logic f_bcast(input logic [DATA_W-1:0] b,
                                   input logic [DATA_W-1:0] a,
                                   input logic [DATA_W-1:0] m);
    logic [DATA_W-1:0] need;
    need = a | m;
    return (b & need) == need;
  endfunction

  assign own_hit   = f_own(byte_in, addr, mask);
  assign bcast_hit = f_bcast(byte_in, addr, mask);
  assign addr_hit  = own_hit | bcast_hit;
endmodule

// File: rtl/rxq_gate.sv
module rxq_gate
  import rxq_pkg::*;
(
  input  logic       frame_done,
  input  logic [1:0] mode,
  input  logic       filt_en,
  input  logic       ri_q,
  input  logic       rx_bit9,
  input  logic       rx_stop,
  input  logic       addr_hit,
  output logic       accept_evt,
  output logic       ferr_evt,
  output logic       ninth_load,
  output logic       ninth_val,
  output logic       filter_rej,
  output logic       busy_drop
);
  logic qual;
  logic uart_mode;

  assign uart_mode = (mode != MODE_SHIFT);

  always_comb begin
    case (rx_mode_e'(mode))
      MODE_SHIFT: qual = 1'b1;
      MODE_UART8: qual = !filt_en || (rx_stop && addr_hit);
      default:    qual = !filt_en || (rx_bit9 && addr_hit);
    endcase
  end

  assign ferr_evt   = frame_done && uart_mode && !rx_stop;
  assign accept_evt = frame_done && !ri_q && qual;
  assign filter_rej = frame_done && !ri_q && !qual;
  assign busy_drop  = frame_done && ri_q;
  assign ninth_load = accept_evt &&
                      (mode[1] || ((mode == MODE_UART8) && !filt_en));
  assign ninth_val  = mode[1] ? rx_bit9 : rx_stop;
endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_fe,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              ri_clr,
  input  logic              accept_evt,
  input  logic              ferr_evt,
  input  logic              ninth_load,
  input  logic              ninth_val,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [1:0]        mode_q,
  output logic              filt_q,
  output logic              ninth_q,
  output logic              ri_q,
  output logic              fe_q,
  output logic [DATA_W-1:0] buf_q,
  output logic [CTL_W-1:0]  ctl_rdata
);
  logic [1:0]        mode_d;
  logic              filt_d, ninth_d, ri_d, fe_d;
  logic [DATA_W-1:0] buf_d;

  always_comb begin
    mode_d  = mode_q;
    filt_d  = filt_q;
    ninth_d = ninth_q;
    ri_d    = ri_q;
    fe_d    = fe_q;
    buf_d   = buf_q;
    if (ri_clr) ri_d = 1'b0;
    if (ctl_wr) begin
      mode_d[0] = ctl_wdata[B_MODELO];
      filt_d    = ctl_wdata[B_FILT];
      ninth_d   = ctl_wdata[B_NINTH];
      ri_d      = ctl_wdata[B_RI];
      if (sel_fe) fe_d      = ctl_wdata[B_MODEHI];
      else        mode_d[1] = ctl_wdata[B_MODEHI];
    end
    if (ferr_evt)   fe_d    = 1'b1;
    if (ninth_load) ninth_d = ninth_val;
    if (accept_evt) begin
      ri_d  = 1'b1;
      buf_d = rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      filt_q  <= 1'b0;
      ninth_q <= 1'b0;
      ri_q    <= 1'b0;
      fe_q    <= 1'b0;
      buf_q   <= '0;
    end else begin
      mode_q  <= mode_d;
      filt_q  <= filt_d;
      ninth_q <= ninth_d;
      ri_q    <= ri_d;
      fe_q    <= fe_d;
      buf_q   <= buf_d;
    end
  end

  always_comb begin
    ctl_rdata           = '0;
    ctl_rdata[B_MODEHI] = sel_fe ? fe_q : mode_q[1];
    ctl_rdata[B_MODELO] = mode_q[0];
    ctl_rdata[B_FILT]   = filt_q;
    ctl_rdata[B_NINTH]  = ninth_q;
    ctl_rdata[B_RI]     = ri_q;
  end
endmodule

// File: rtl/uart_rx_qualifier.sv
module uart_rx_qualifier
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_bit9,
  input  logic              rx_stop,
  input  logic [DATA_W-1:0] stn_addr,
  input  logic [DATA_W-1:0] stn_mask,
  input  logic              sel_fe,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic              ri_clr,
  output logic [7:0]        ctl_rdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              ri,
  output logic              fe,
  output logic              ninth
);
  logic       own_hit, bcast_hit, addr_hit;
  logic       accept_evt, ferr_evt, ninth_load, ninth_val;
  logic       filter_rej, busy_drop;
  logic [1:0] mode_q;
  logic       filt_q, ri_q, fe_q, ninth_q;

  rxq_addr_match #(.DATA_W(DATA_W)) u_match (
    .byte_in  (rx_byte),
    .addr     (stn_addr),
    .mask     (stn_mask),
    .own_hit  (own_hit),
    .bcast_hit(bcast_hit),
    .addr_hit (addr_hit)
  );

  rxq_gate u_gate (
    .frame_done(frame_done),
    .mode      (mode_q),
    .filt_en   (filt_q),
    .ri_q      (ri_q),
    .rx_bit9   (rx_bit9),
    .rx_stop   (rx_stop),
    .addr_hit  (addr_hit),
    .accept_evt(accept_evt),
    .ferr_evt  (ferr_evt),
    .ninth_load(ninth_load),
    .ninth_val (ninth_val),
    .filter_rej(filter_rej),
    .busy_drop (busy_drop)
  );

  rxq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_fe    (sel_fe),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ri_clr    (ri_clr),
    .accept_evt(accept_evt),
    .ferr_evt  (ferr_evt),
    .ninth_load(ninth_load),
    .ninth_val (ninth_val),
    .rx_byte   (rx_byte),
    .mode_q    (mode_q),
    .filt_q    (filt_q),
    .ninth_q   (ninth_q),
    .ri_q      (ri_q),
    .fe_q      (fe_q),
    .buf_q     (rx_data),
    .ctl_rdata (ctl_rdata)
  );

  assign ri    = ri_q;
  assign fe    = fe_q;
  assign ninth = ninth_q;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_done,
  input logic              rx_stop,
  input logic              rx_bit9,
  input logic [DATA_W-1:0] rx_byte,
  input logic              sel_fe,
  input logic              ctl_wr,
  input logic [7:0]        ctl_wdata,
  input logic              ri_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              ri,
  input logic              fe,
  input logic [1:0]        mode_q,
  input logic              filt_q,
  input logic              accept_evt,
  input logic              filter_rej,
  input logic              busy_drop,
  input logic              own_hit,
  input logic              bcast_hit
);
  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (ri && rx_data == $past(rx_byte)));                 // R2

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && ri) |=> $stable(rx_data));                         // R10

  AST_BUSY_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_drop |-> !accept_evt);                                       // R10

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    filter_rej |=> $stable(rx_data));                                 // R5

  AST_NINE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && filt_q && mode_q[1] && !rx_bit9) |=> $stable(rx_data)); // R5

  AST_MODE1_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && filt_q && mode_q == 2'd1 && !rx_stop) |=> $stable(rx_data)); // R6

  AST_FILTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && filt_q && mode_q != 2'd0) |-> (own_hit || bcast_hit)); // R7

  AST_FE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !rx_stop && mode_q != 2'd0) |=> fe);               // R8

  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !(ctl_wr && sel_fe && !ctl_wdata[7])) |=> fe);             // R8

  AST_MODEHI_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && sel_fe) |=> $stable(mode_q[1]));                       // R9

  AST_RI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_clr && !accept_evt && !ctl_wr) |=> !ri);                      // R11
endmodule

bind uart_rx_qualifier rxq_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_done(frame_done),
  .rx_stop   (rx_stop),
  .rx_bit9   (rx_bit9),
  .rx_byte   (rx_byte),
  .sel_fe    (sel_fe),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .ri_clr    (ri_clr),
  .rx_data   (rx_data),
  .ri        (ri),
  .fe        (fe),
  .mode_q    (mode_q),
  .filt_q    (filt_q),
  .accept_evt(accept_evt),
  .filter_rej(filter_rej),
  .busy_drop (busy_drop),
  .own_hit   (own_hit),
  .bcast_hit (bcast_hit)
);

// File: tb/tb_uart_rx_qualifier.sv
module tb_uart_rx_qualifier;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_done = 1'b0;
  logic [DATA_W-1:0] rx_byte = '0;
  logic              rx_bit9 = 1'b0;
  logic              rx_stop = 1'b1;
  logic [DATA_W-1:0] stn_addr = 8'h24;
  logic [DATA_W-1:0] stn_mask = 8'h0F;
  logic              sel_fe = 1'b0;
  logic              ctl_wr = 1'b0;
  logic [7:0]        ctl_wdata = '0;
  logic              ri_clr = 1'b0;
  logic [7:0]        ctl_rdata;
  logic [DATA_W-1:0] rx_data;
  logic              ri, fe, ninth;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  uart_rx_qualifier #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .rx_byte(rx_byte),
    .rx_bit9(rx_bit9), .rx_stop(rx_stop), .stn_addr(stn_addr),
    .stn_mask(stn_mask), .sel_fe(sel_fe), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ri_clr(ri_clr), .ctl_rdata(ctl_rdata),
    .rx_data(rx_data), .ri(ri), .fe(fe), .ninth(ninth)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one-cycle strobes driven at the falling edge; results sampled one cycle later
  task automatic frame(input logic [7:0] b, input logic b9, input logic stp);
    @(negedge clk);
    rx_byte = b; rx_bit9 = b9; rx_stop = stp; frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] d, input logic s);
    @(negedge clk);
    sel_fe = s; ctl_wdata = d; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic clr_ri();
    @(negedge clk);
    ri_clr = 1'b1;
    @(negedge clk);
    ri_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "rdata", ctl_rdata, 8'h00);
    chk("R1", "buffer", rx_data, 8'h00);
    chk("R1", "ri/fe/ninth", {5'd0, ri, fe, ninth}, 8'h00);
  endtask

  task automatic t_mode0();
    wr_ctl(8'h00, 1'b0);
    frame(8'h3C, 1'b1, 1'b0);
    chk("R2", "buffer", rx_data, 8'h3C);
    chk("R2", "ri", {7'd0, ri}, 8'h01);
    chk("R2", "ninth/fe untouched", {6'd0, ninth, fe}, 8'h00);
    frame(8'h77, 1'b1, 1'b1);
    chk("R10", "busy frame dropped", rx_data, 8'h3C);
    clr_ri();
    chk("R11", "ri cleared", {7'd0, ri}, 8'h00);
  endtask

  task automatic t_mode2_open();
    wr_ctl(8'h80, 1'b0);
    frame(8'h15, 1'b1, 1'b1);
    chk("R3", "buffer", rx_data, 8'h15);
    chk("R3", "ninth", {7'd0, ninth}, 8'h01);
    chk("R9", "rdata mode2", ctl_rdata, 8'h85);
    wr_ctl(8'h80, 1'b0);
    chk("R3", "ri/ninth written 0", {6'd0, ri, ninth}, 8'h00);
  endtask

  task automatic t_mode3_filter();
    wr_ctl(8'hE0, 1'b0);
    frame(8'h14, 1'b0, 1'b1);
    chk("R5", "data frame rejected ri", {7'd0, ri}, 8'h00);
    chk("R5", "data frame rejected buf", rx_data, 8'h15);
    frame(8'h15, 1'b1, 1'b1);
    chk("R7", "mismatch rejected", {6'd0, ri, ninth}, 8'h00);
    frame(8'h14, 1'b1, 1'b1);
    chk("R7", "own match buf", rx_data, 8'h14);
    chk("R5", "own match ri/ninth", {6'd0, ri, ninth}, 8'h03);
    clr_ri();
    frame(8'hEF, 1'b1, 1'b1);
    chk("R7", "broadcast match buf", rx_data, 8'hEF);
    clr_ri();
  endtask

  task automatic t_mode1_open();
    wr_ctl(8'h40, 1'b0);
    frame(8'h5A, 1'b0, 1'b0);
    chk("R4", "bad stop still delivered", rx_data, 8'h5A);
    chk("R4", "ninth=stop", {6'd0, ri, ninth}, 8'h02);
    chk("R8", "fe set", {7'd0, fe}, 8'h01);
    chk("R9", "rdata sel=0", ctl_rdata, 8'h41);
    @(negedge clk); sel_fe = 1'b1; #1;
    chk("R9", "rdata sel=1", ctl_rdata, 8'hC1);
    @(negedge clk); sel_fe = 1'b0;
    clr_ri();
    frame(8'h66, 1'b0, 1'b1);
    chk("R4", "ninth=stop 1", {7'd0, ninth}, 8'h01);
    chk("R8", "fe sticky", {7'd0, fe}, 8'h01);
  endtask

  task automatic t_mode1_filter();
    wr_ctl(8'h64, 1'b0);
    chk("R9", "sel=0 write keeps fe", {7'd0, fe}, 8'h01);
    frame(8'h14, 1'b0, 1'b0);
    chk("R6", "bad stop rejected", {6'd0, ri, ninth}, 8'h01);
    chk("R6", "bad stop buf", rx_data, 8'h66);
    frame(8'h33, 1'b0, 1'b1);
    chk("R6", "mismatch rejected", {7'd0, ri}, 8'h00);
    frame(8'h14, 1'b0, 1'b1);
    chk("R6", "accept buf", rx_data, 8'h14);
    chk("R6", "accept ri, ninth kept", {6'd0, ri, ninth}, 8'h03);
  endtask

  task automatic t_shared_bit();
    wr_ctl(8'h60, 1'b1);
    chk("R9", "fe cleared by write", {7'd0, fe}, 8'h00);
    chk("R9", "rdata sel=1", ctl_rdata, 8'h60);
    wr_ctl(8'hE0, 1'b1);
    chk("R9", "fe written 1", {7'd0, fe}, 8'h01);
    @(negedge clk); sel_fe = 1'b0; #1;
    chk("R9", "mode hi untouched", ctl_rdata, 8'h60);
    wr_ctl(8'h60, 1'b1);
    @(negedge clk); sel_fe = 1'b0;
  endtask

  task automatic t_priority();
    @(negedge clk);
    rx_byte = 8'h14; rx_bit9 = 1'b0; rx_stop = 1'b1;
    frame_done = 1'b1; ri_clr = 1'b1;
    @(negedge clk);
    frame_done = 1'b0; ri_clr = 1'b0;
    chk("R11", "delivery beats clear", {7'd0, ri}, 8'h01);
    frame(8'h1F, 1'b0, 1'b0);
    chk("R10", "busy drop buf", rx_data, 8'h14);
    chk("R8", "fe set on dropped frame", {7'd0, fe}, 8'h01);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode2_open();
    t_mode3_filter();
    t_mode1_open();
    t_mode1_filter();
    t_shared_bit();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule